// File: doc/BRIEF.md
# Tick Counter Unit With Compare Interrupts

This block holds a small set of free-running cycle counters, each paired with a compare limit. Every counter advances by one on each cycle in which the shared clock enable is high. Software can load a counter, read it back and program its limit through a single write port and a single read port, selecting the counter by index. When an armed, enabled counter steps onto its limit, a sticky bit in a two-bit software-interrupt register is set. Counter 0 drives the tick-match bit. Every other counter drives the system-tick-match bit. Software clears that register with a masked clear strobe.

The top bit of every written word is a disable flag and is held apart from the numeric value in the bits below it. Writing a counter or a limit updates the flag. A read returns the running value with the flag in the top bit. A limit that is zero or that is written with the flag set never arms. A limit written at or behind the current count fires on the next tick. The default configuration has three counters: tick, system tick and hypervisor system tick.

Top module: `tick_compare_unit`

## Requirements
- R1: After reset every counter reads as zero with its disable flag (bit CNT_W-1) set, no compare is armed, and `sint` is 0.
- R2: A counter adds one to its numeric part (bits CNT_W-2:0) on every cycle in which `tick_en` is high and it is not being written. The value wraps from all ones to zero, and the counter holds while `tick_en` is low. Counting continues while the counter is disabled.
- R3: `cnt_wr` loads bits CNT_W-2:0 of `wr_data` into counter `wr_sel` and takes its disable flag from bit CNT_W-1. The load takes effect at the clock edge and overrides a tick in the same cycle.
- R4: `rd_data` combinationally shows counter `rd_sel` as {disable flag, numeric count}.
- R5: `lim_wr` loads bits CNT_W-2:0 of `wr_data` as the limit of counter `wr_sel` and sets that counter's disable flag from bit CNT_W-1. The compare is armed only if the numeric limit is nonzero and bit CNT_W-1 is clear.
- R6: When an armed counter ticks onto its limit, the compare fires once and disarms. If the counter is enabled, its `sint` bit is 1 from the same clock edge at which the count becomes the limit. A further fire needs a new limit write.
- R7: If a limit write arms a limit that is less than or equal to the count that holds after that cycle, the compare fires at the next tick.
- R8: A zero limit never fires. A fire on a counter whose disable flag is set raises no `sint` bit and still disarms the compare. This includes a counter disabled by a count write after its limit was armed.
- R9: Counter 0 sets `sint[0]` (tick match). Every counter with index 1 or higher sets `sint[1]` (system-tick match).
- R10: `sint` bits stay set until `sint_clr` is high with a 1 in the matching bit of `sint_clr_mask`. A fire in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable: one step per high cycle |
| cnt_wr | input | 1 | Load the selected counter from `wr_data` |
| lim_wr | input | 1 | Load the selected limit from `wr_data` |
| wr_sel | input | SEL_W | Index of the counter being written |
| wr_data | input | CNT_W | Write word: bit CNT_W-1 is the disable flag, the bits below are the value |
| rd_sel | input | SEL_W | Index of the counter being read |
| rd_data | output | CNT_W | Selected counter with its disable flag in the top bit |
| sint_clr | input | 1 | Clear strobe for the software-interrupt bits |
| sint_clr_mask | input | 2 | Bits to clear when `sint_clr` is high |
| sint | output | 2 | Software-interrupt bits: [0] tick match, [1] system-tick match |

## Verification
The bench builds the unit with CNT_W = 16 and NUM_TMR = 3. The 15-bit count makes wraparound reachable, and randomly chosen limits land close to the running counts, so hits, late arms and missed limits all occur often. With three counters, both routing targets are exercised, and two counters share `sint[1]`. A behavioural model checks `rd_data` and `sint` on every cycle under random traffic. Directed sequences cover late limits, disabling a counter after its limit is armed, and a fire in the same cycle as a clear.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int SINT_W     = 2;
  localparam int SINT_TICK  = 0;
  localparam int SINT_STICK = 1;
endpackage

// File: rtl/tcu_rst_sync.sv
module tcu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tcu_timer.sv
module tcu_timer #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_val,
  output logic             match_o
);
  localparam int VW = CNT_W - 1;

  logic [VW-1:0] cnt_q, cnt_d, cnt_inc, lim_q, lim_d;
  logic          dis_q, dis_d, arm_q, arm_d, late_q, late_d;
  logic          hit;

  always_comb begin
    cnt_inc = cnt_q + VW'(1);
    cnt_d   = cnt_q;
    dis_d   = dis_q;
    lim_d   = lim_q;
    arm_d   = arm_q;
    late_d  = late_q;
    hit     = tick_en && !cnt_wr && !lim_wr && arm_q &&
              (late_q || (cnt_inc == lim_q));
    if (cnt_wr) begin
      cnt_d = wr_data[VW-1:0];
      dis_d = wr_data[VW];
    end else if (tick_en) begin
      cnt_d = cnt_inc;
    end
    if (hit) begin
      arm_d  = 1'b0;
      late_d = 1'b0;
    end
    if (lim_wr) begin
      lim_d  = wr_data[VW-1:0];
      dis_d  = wr_data[VW];
      arm_d  = (wr_data[VW-1:0] != '0) && !wr_data[VW];
      late_d = (wr_data[VW-1:0] <= cnt_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      dis_q  <= 1'b1;
      arm_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      dis_q  <= dis_d;
      arm_q  <= arm_d;
      late_q <= late_d;
    end
  end

  assign match_o = hit && !dis_q;
  assign rd_val  = {dis_q, cnt_q};

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + VW'(1)));

  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data[VW-1:0])));

  assert_masked_limit_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && wr_data[VW]) |=> !arm_q);

  assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !arm_q);

  assert_zero_limit_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && (wr_data[VW-1:0] == '0)) |=> !arm_q);
endmodule

// File: rtl/tcu_sint_reg.sv
module tcu_sint_reg
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SINT_W-1:0] set_vec,
  input  logic              clr,
  input  logic [SINT_W-1:0] clr_mask,
  output logic [SINT_W-1:0] sint_q
);
  logic [SINT_W-1:0] sint_d;

  always_comb begin
    sint_d = sint_q;
    if (clr) sint_d = sint_d & ~clr_mask;
    sint_d = sint_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sint_q <= '0;
    else        sint_q <= sint_d;
  end

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((sint_q & $past(sint_q)) == $past(sint_q)));

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sint_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/tick_compare_unit.sv
module tick_compare_unit
  import tick_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int NUM_TMR = 3,
  localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cnt_wr,
  input  logic              lim_wr,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              sint_clr,
  input  logic [SINT_W-1:0] sint_clr_mask,
  output logic [SINT_W-1:0] sint
);
  logic               rst_n_s;
  logic [CNT_W-1:0]   rd_vals [NUM_TMR];
  logic [NUM_TMR-1:0] tmatch;
  logic [SINT_W-1:0]  sint_set;

  tcu_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tcu_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .tick_en (tick_en),
      .cnt_wr  (cnt_wr && (wr_sel == SEL_W'(g))),
      .lim_wr  (lim_wr && (wr_sel == SEL_W'(g))),
      .wr_data (wr_data),
      .rd_val  (rd_vals[g]),
      .match_o (tmatch[g])
    );
  end

  always_comb begin
    sint_set = '0;
    sint_set[SINT_TICK] = tmatch[0];
    for (int i = 1; i < NUM_TMR; i++) begin
      sint_set[SINT_STICK] = sint_set[SINT_STICK] | tmatch[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = rd_vals[i];
    end
  end

  tcu_sint_reg u_sint (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_vec  (sint_set),
    .clr      (sint_clr),
    .clr_mask (sint_clr_mask),
    .sint_q   (sint)
  );

  assert_tick_route_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sint[SINT_TICK] && !$past(sint[SINT_TICK])) |-> $past(tmatch[0]));

  if (NUM_TMR > 1) begin : g_stick_chk
    assert_stick_route_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
      (sint[SINT_STICK] && !$past(sint[SINT_STICK])) |-> $past(tmatch[NUM_TMR-1:1] != '0));
  end
endmodule

// File: tb/test_tick_compare_unit.sv
module test_tick_compare_unit;
  localparam int CW = 16;
  localparam int NT = 3;
  localparam int VW = CW - 1;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0, cnt_wr = 1'b0, lim_wr = 1'b0, sint_clr = 1'b0;
  logic [SW-1:0] wr_sel = '0, rd_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0]    sint_clr_mask = '0;
  logic [CW-1:0] rd_data;
  logic [1:0]    sint;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  tick_compare_unit #(.CNT_W(CW), .NUM_TMR(NT)) i_tick_compare_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr), .lim_wr(lim_wr),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .sint_clr(sint_clr), .sint_clr_mask(sint_clr_mask), .sint(sint)
  );

  // Behavioural reference model
  logic [VW-1:0] m_cnt [NT];
  logic [VW-1:0] m_lim [NT];
  bit            m_dis [NT];
  bit            m_arm [NT];
  bit            m_late[NT];
  logic [1:0]    m_sint;

  always @(posedge clk) begin
    logic [1:0] setb;
    setb = 2'b00;
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_cnt[i] = '0; m_lim[i] = '0; m_dis[i] = 1; m_arm[i] = 0; m_late[i] = 0;
      end
      m_sint = 2'b00;
    end else begin
      for (int i = 0; i < NT; i++) begin
        bit wc, wl;
        logic [VW-1:0] stepv, nc;
        wc = cnt_wr && (int'(wr_sel) == i);
        wl = lim_wr && (int'(wr_sel) == i);
        stepv = m_cnt[i] + 1'b1;
        nc = wc ? wr_data[VW-1:0] : (tick_en ? stepv : m_cnt[i]);
        if (!wc && !wl && tick_en && m_arm[i] && (m_late[i] || stepv == m_lim[i])) begin
          m_arm[i] = 0; m_late[i] = 0;
          if (!m_dis[i]) setb[(i == 0) ? 0 : 1] = 1'b1;
        end
        if (wc) m_dis[i] = wr_data[VW];
        if (wl) begin
          m_lim[i]  = wr_data[VW-1:0];
          m_dis[i]  = wr_data[VW];
          m_arm[i]  = (wr_data[VW-1:0] != 0) && !wr_data[VW];
          m_late[i] = (wr_data[VW-1:0] <= nc);
        end
        m_cnt[i] = nc;
      end
      if (sint_clr) m_sint = m_sint & ~sint_clr_mask;
      m_sint = m_sint | setb;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== {m_dis[rd_sel], m_cnt[rd_sel]} || sint !== m_sint) begin
        errors++;
        $display("FAIL MODEL R4/R10 actual rd=%h sint=%b expected rd=%h sint=%b",
                 rd_data, sint, {m_dis[rd_sel], m_cnt[rd_sel]}, m_sint);
      end
    end
  end

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look_rd(input int sel, input logic [CW-1:0] exp, input string tag);
    @(negedge clk); #2;
    rd_sel = SW'(sel);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic look_sint(input logic [1:0] exp, input string tag);
    @(negedge clk); #2;
    chk(tag, CW'(sint), CW'(exp));
  endtask

  task automatic step(input bit t, input bit wc, input bit wl, input int sel,
                      input logic [CW-1:0] d, input bit c, input logic [1:0] m);
    @(negedge clk); #1;
    tick_en = t; cnt_wr = wc; lim_wr = wl; wr_sel = SW'(sel); wr_data = d;
    sint_clr = c; sint_clr_mask = m;
    @(posedge clk); #1;
    tick_en = 0; cnt_wr = 0; lim_wr = 0; sint_clr = 0; sint_clr_mask = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1, 0, 0, 0, '0, 0, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    look_rd(0, 16'h8000, "R1 timer0 after reset");
    look_rd(2, 16'h8000, "R1 timer2 after reset");
    look_sint(2'b00, "R1 sint after reset");

    // R3 load, R2 count and hold
    step(0, 1, 0, 0, 16'h0010, 0, 2'b00);
    look_rd(0, 16'h0010, "R3 count load");
    ticks(5);
    look_rd(0, 16'h0015, "R2 five ticks");
    look_rd(1, 16'h8005, "R2/R4 disabled timer keeps counting, flag read back");
    repeat (3) @(posedge clk);
    look_rd(0, 16'h0015, "R2 hold without tick_en");

    // R6 match timing, R9 routing, R10 sticky/clear
    step(0, 0, 1, 0, 16'h0018, 0, 2'b00);
    ticks(2);
    look_rd(0, 16'h0017, "R6 count before limit");
    look_sint(2'b00, "R6 no early fire");
    ticks(1);
    look_rd(0, 16'h0018, "R6 count at limit");
    look_sint(2'b01, "R6/R9 tick match sets bit0");
    ticks(1);
    look_sint(2'b01, "R10 bit stays set");
    step(0, 0, 0, 0, '0, 1, 2'b01);
    look_sint(2'b00, "R10 masked clear");
    ticks(3);
    look_sint(2'b00, "R6 fires only once");

    // R7 late limit on timer 1
    step(0, 1, 0, 1, 16'h0100, 0, 2'b00);
    step(0, 0, 1, 1, 16'h0050, 0, 2'b00);
    look_sint(2'b00, "R7 late limit waits for tick");
    ticks(1);
    look_sint(2'b10, "R7/R9 late limit fires on next tick to bit1");
    step(0, 0, 0, 0, '0, 1, 2'b10);

    // R9 timer 2 routing
    step(0, 1, 0, 2, 16'h0200, 0, 2'b00);
    step(0, 0, 1, 2, 16'h0202, 0, 2'b00);
    ticks(2);
    look_sint(2'b10, "R9 timer2 sets bit1");
    step(0, 0, 0, 0, '0, 1, 2'b11);

    // R8 zero limit, disabled limit, disable after arm
    step(0, 1, 0, 0, 16'h0020, 0, 2'b00);
    step(0, 0, 1, 0, 16'h0000, 0, 2'b00);
    ticks(40);
    look_sint(2'b00, "R8 zero limit never fires");
    step(0, 1, 0, 0, 16'h0030, 0, 2'b00);
    step(0, 0, 1, 0, 16'h8032, 0, 2'b00);
    ticks(4);
    look_sint(2'b00, "R8 limit written disabled does not fire");
    look_rd(0, 16'h8034, "R5 limit write sets disable flag");
    step(0, 1, 0, 0, 16'h0300, 0, 2'b00);
    step(0, 0, 1, 0, 16'h0303, 0, 2'b00);
    step(0, 1, 0, 0, 16'h8301, 0, 2'b00);
    ticks(4);
    look_sint(2'b00, "R8 disabled after arm raises nothing");
    look_rd(0, 16'h8305, "R4 disabled read");
    step(0, 1, 0, 0, 16'h0305, 0, 2'b00);
    ticks(4);
    look_sint(2'b00, "R8 fire consumed while disabled");

    // R2 wrap
    step(0, 1, 0, 0, 16'h7FFE, 0, 2'b00);
    ticks(2);
    look_rd(0, 16'h0000, "R2 wrap to zero");

    // R10 set beats clear
    step(0, 0, 1, 0, 16'h0002, 0, 2'b00);
    ticks(1);
    step(1, 0, 0, 0, '0, 1, 2'b01);
    look_sint(2'b01, "R10 fire wins over clear");
    step(0, 0, 0, 0, '0, 1, 2'b11);

    // R3 write overrides tick
    step(1, 1, 0, 0, 16'h0040, 0, 2'b00);
    look_rd(0, 16'h0040, "R3 write beats tick");

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int sel, op;
      sel = int'($urandom % NT);
      op  = int'($urandom % 8);
      c = {($urandom % 4) == 0, VW'(m_cnt[sel] + VW'($urandom % 12) - VW'(3))};
      if (op == 0)      step($urandom % 2 == 0, 1, 0, sel, c, 0, 2'b00);
      else if (op == 1) step($urandom % 2 == 0, 0, 1, sel, c, 0, 2'b00);
      else if (op == 2) step(1, 0, 0, 0, '0, 1, 2'($urandom));
      else              step($urandom % 4 != 0, 0, 0, 0, '0, 0, 2'b00);
      rd_sel = SW'($urandom % NT);
    end

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule